// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block connects synchronous on-chip logic to an external asynchronous static RAM of 512K words by 8 bits. Clients issue one word at a time over a valid/ready request port. A write carries an address and a byte. A read returns its byte on a response port, qualified by a single-cycle valid strobe. Only one access is in flight at any time.

The memory side has a 19-bit address, active-low chip select, write enable and output enable, and a data bus split into an output byte, an output-enable flag for the pad driver, and an input byte. Every pin is driven from a register. Each phase of an access is counted in clock cycles. Those counts are derived at elaboration from the clock period and the memory's nanosecond limits, always rounded up. After reset the block keeps the memory deselected and refuses all requests until 150 µs have passed.

Writes are controlled by write enable, with output enable held high throughout. The memory therefore never drives the bus while the controller does. After every access there is a turnaround phase, which gives the memory time to release the bus.

Top module: `sram_ctl`

## Requirements
- R1: After reset release, `req_ready` stays low and `mem_cs_n` stays high for PU cycles, where PU = ceil(150 µs / clock period) (30000 at 5 ns). `req_ready` is low at the sample after rising edge PU and high at the sample after rising edge PU+1.
- R2: Requests presented during the power-up wait are ignored. The memory is never selected and no response appears. A write offered during the wait leaves the memory contents unchanged.
- R3: In a write, chip select falls one cycle before write enable falls. Write enable stays low for WP = max(ceil(8 ns), ceil(6 ns)) cycles (2 at 5 ns). Output enable stays high throughout.
- R4: The controller drives the data bus (`mem_dq_oe` = 1) from the first cycle of write enable low through one hold cycle after write enable rises, which is WP+1 cycles. Address and data are unchanged over that span.
- R5: A read holds chip select and output enable low, with write enable high, for ACC = ceil(10 ns) cycles (2 at 5 ns). Input data is sampled at the edge that ends the last access cycle. That data appears on `rsp_data` with `rsp_valid` high for exactly one cycle. Responses come back in request order.
- R6: `rsp_data` holds the last read value until the next read completes, including across writes.
- R7: The controller never drives the bus while output enable is low. In the cycle before output enable falls, the driver is already off.
- R8: `req_ready` falls on acceptance and returns after the turnaround completes. That is 5 cycles after a write is accepted (setup 1, strobe WP, hold 1, turnaround 1) and 4 cycles after a read is accepted (access ACC, capture 1, turnaround 1).
- R9: Whenever the block is ready for a request, chip select, write enable and output enable are all high and the data driver is off.
- R10: A request held valid is accepted in the first cycle `req_ready` returns. A read issued right after a write to the same address returns the newly written byte, including at addresses 0 and 0x7FFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 19 | Word address |
| req_wdata | input | 8 | Write byte |
| rsp_valid | output | 1 | One-cycle read-data strobe |
| rsp_data | output | 8 | Last read byte |
| mem_addr | output | 19 | Memory address pins |
| mem_cs_n | output | 1 | Memory chip select, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_dq_out | output | 8 | Byte toward the data pins |
| mem_dq_oe | output | 1 | Data pad driver enable |
| mem_dq_in | input | 8 | Byte from the data pins |

## Verification
Two things share one clock edge in this block. The read-data capture happens on the same edge that raises output enable. The return of `req_ready` is the same cycle in which a held request is taken. The bench memory model presents a valid byte only after output enable has been low for ACC samples, and a junk value 0xEE at every other time. A capture that is early or late therefore shows up in the scoreboard as a data mismatch. The driver keeps the next request valid the moment `req_ready` returns, and it compares the measured ready latency against the R8 counts. A read that follows a write to the same address must return the new byte.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_INIT_WAIT,
        ST_WR_SETUP,
        ST_WR_STROBE,
        ST_WR_HOLD,
        ST_RD_ACCESS,
        ST_RD_CAPTURE,
        ST_TURNAROUND
    } ctl_state_e;

    // Round a nanosecond limit up to whole clock cycles.
    function automatic int ns_to_cyc(input int lim_ns, input int clk_ps);
        longint num;
        num = longint'(lim_ns) * 64'sd1000 + longint'(clk_ps) - 64'sd1;
        return int'(num / longint'(clk_ps));
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_ctl_powerup.sv
module sram_ctl_powerup #(
    parameter int PU_CYC = 30000
) (
    input  logic clk,
    input  logic rst_n,
    output logic done_o
);
    localparam int CNT_W = (PU_CYC > 1) ? $clog2(PU_CYC) : 1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             done;
    } pu_t;

    pu_t pu_d, pu_q;

    always_comb begin
        pu_d = pu_q;
        if (!pu_q.done) begin
            if (pu_q.cnt == CNT_W'(PU_CYC - 1)) begin
                pu_d.done = 1'b1;
            end else begin
                pu_d.cnt = pu_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pu_q <= '0;
        end else begin
            pu_q <= pu_d;
        end
    end

    assign done_o = pu_q.done;

    // R1
    done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> done_o);

endmodule

// File: rtl/sram_ctl_seq.sv
module sram_ctl_seq
    import sram_ctl_pkg::*;
#(
    parameter int ADDR_W   = 19,
    parameter int DATA_W   = 8,
    parameter int SETUP_C  = 1,
    parameter int STROBE_C = 2,
    parameter int HOLD_C   = 1,
    parameter int ACCESS_C = 2,
    parameter int TURN_C   = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pu_done_i,
    input  logic              req_valid_i,
    input  logic              req_write_i,
    input  logic [ADDR_W-1:0] req_addr_i,
    input  logic [DATA_W-1:0] req_wdata_i,
    output logic              req_ready_o,
    output logic              rsp_valid_o,
    output logic [DATA_W-1:0] rsp_data_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic              mem_cs_n_o,
    output logic              mem_we_n_o,
    output logic              mem_oe_n_o,
    output logic [DATA_W-1:0] mem_dq_o,
    output logic              mem_dq_oe_o,
    input  logic [DATA_W-1:0] mem_dq_i
);
    localparam int MAXC = max2(max2(max2(SETUP_C, STROBE_C), max2(HOLD_C, ACCESS_C)), TURN_C);
    localparam int CW   = $clog2(MAXC + 1);

    typedef struct packed {
        ctl_state_e        st;
        logic [CW-1:0]     cnt;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] dout;
        logic              dq_oe;
        logic              cs_n;
        logic              we_n;
        logic              oe_n;
        logic [DATA_W-1:0] rdata;
        logic              rvalid;
    } seq_t;

    seq_t s_d, s_q;
    logic cnt_zero;

    assign cnt_zero = (s_q.cnt == '0);

    always_comb begin
        s_d        = s_q;
        s_d.rvalid = 1'b0;
        unique case (s_q.st)
            ST_INIT_WAIT: begin
                if (pu_done_i) s_d.st = ST_IDLE;
            end
            ST_IDLE: begin
                if (req_valid_i) begin
                    s_d.addr = req_addr_i;
                    s_d.cs_n = 1'b0;
                    if (req_write_i) begin
                        s_d.st   = ST_WR_SETUP;
                        s_d.dout = req_wdata_i;
                        s_d.oe_n = 1'b1;
                        s_d.cnt  = CW'(SETUP_C - 1);
                    end else begin
                        s_d.st   = ST_RD_ACCESS;
                        s_d.oe_n = 1'b0;
                        s_d.cnt  = CW'(ACCESS_C - 1);
                    end
                end
            end
            ST_WR_SETUP: begin
                if (cnt_zero) begin
                    s_d.st    = ST_WR_STROBE;
                    s_d.we_n  = 1'b0;
                    s_d.dq_oe = 1'b1;
                    s_d.cnt   = CW'(STROBE_C - 1);
                end else begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end
            end
            ST_WR_STROBE: begin
                if (cnt_zero) begin
                    s_d.st   = ST_WR_HOLD;
                    s_d.we_n = 1'b1;
                    s_d.cnt  = CW'(HOLD_C - 1);
                end else begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end
            end
            ST_WR_HOLD: begin
                if (cnt_zero) begin
                    s_d.st    = ST_TURNAROUND;
                    s_d.cs_n  = 1'b1;
                    s_d.dq_oe = 1'b0;
                    s_d.cnt   = CW'(TURN_C - 1);
                end else begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end
            end
            ST_RD_ACCESS: begin
                if (cnt_zero) begin
                    s_d.st     = ST_RD_CAPTURE;
                    s_d.rdata  = mem_dq_i;
                    s_d.rvalid = 1'b1;
                    s_d.cs_n   = 1'b1;
                    s_d.oe_n   = 1'b1;
                end else begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end
            end
            ST_RD_CAPTURE: begin
                s_d.st  = ST_TURNAROUND;
                s_d.cnt = CW'(TURN_C - 1);
            end
            ST_TURNAROUND: begin
                if (cnt_zero) begin
                    s_d.st = ST_IDLE;
                end else begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q      <= '0;
            s_q.st   <= ST_INIT_WAIT;
            s_q.cs_n <= 1'b1;
            s_q.we_n <= 1'b1;
            s_q.oe_n <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign req_ready_o = (s_q.st == ST_IDLE);
    assign rsp_valid_o = s_q.rvalid;
    assign rsp_data_o  = s_q.rdata;
    assign mem_addr_o  = s_q.addr;
    assign mem_cs_n_o  = s_q.cs_n;
    assign mem_we_n_o  = s_q.we_n;
    assign mem_oe_n_o  = s_q.oe_n;
    assign mem_dq_o    = s_q.dout;
    assign mem_dq_oe_o = s_q.dq_oe;

    // Length of the current write-enable low pulse, for the width check.
    logic [CW:0] we_lo_cnt;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            we_lo_cnt <= '0;
        end else if (mem_we_n_o) begin
            we_lo_cnt <= '0;
        end else if (we_lo_cnt != '1) begin
            we_lo_cnt <= we_lo_cnt + 1'b1;
        end
    end

    // R1
    lockout_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pu_done_i |-> (mem_cs_n_o && !req_ready_o));

    // R3
    we_ctrl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n_o |-> (!mem_cs_n_o && mem_oe_n_o));

    // R3
    we_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n_o) |-> (we_lo_cnt == (CW+1)'(STROBE_C)));

    // R4
    wr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_we_n_o && $past(!mem_we_n_o)) |->
            ($stable(mem_addr_o) && $stable(mem_dq_o) && mem_dq_oe_o));

    // R5
    rvalid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid_o |=> !rsp_valid_o);

    // R7
    bus_fight_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe_o |-> mem_oe_n_o);

    // R7
    oe_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_oe_n_o) |-> !$past(mem_dq_oe_o));

    // R8
    ready_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && req_ready_o) |=> !req_ready_o);

    // R9
    idle_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready_o |-> (mem_cs_n_o && mem_we_n_o && mem_oe_n_o && !mem_dq_oe_o));

endmodule

// File: rtl/sram_ctl.sv
module sram_ctl
    import sram_ctl_pkg::*;
#(
    parameter int ADDR_W     = 19,
    parameter int DATA_W     = 8,
    parameter int CLK_PS     = 5000,
    parameter int PU_NS      = 150000,
    parameter int SETUP_CYC  = 1,
    parameter int T_WC_NS    = 10,
    parameter int T_PWE_NS   = 8,
    parameter int T_SD_NS    = 6,
    parameter int T_AA_NS    = 10,
    parameter int T_DOE_NS   = 6,
    parameter int T_RC_NS    = 10,
    parameter int T_HZ_NS    = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_cs_n,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_in
);
    localparam int PU_C  = max2(1, ns_to_cyc(PU_NS, CLK_PS));
    localparam int WS_C  = max2(1, SETUP_CYC);
    localparam int WP_C  = max2(1, max2(ns_to_cyc(T_PWE_NS, CLK_PS), ns_to_cyc(T_SD_NS, CLK_PS)));
    localparam int WH_C  = max2(1, ns_to_cyc(T_WC_NS, CLK_PS) - WS_C - WP_C);
    localparam int TA_C  = max2(1, ns_to_cyc(T_HZ_NS, CLK_PS));
    localparam int ACC_C = max2(1, max2(max2(ns_to_cyc(T_AA_NS, CLK_PS), ns_to_cyc(T_DOE_NS, CLK_PS)),
                                        ns_to_cyc(T_RC_NS, CLK_PS) - 1 - TA_C));

    logic pu_done;

    sram_ctl_powerup #(
        .PU_CYC (PU_C)
    ) u_powerup (
        .clk    (clk),
        .rst_n  (rst_n),
        .done_o (pu_done)
    );

    sram_ctl_seq #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .SETUP_C  (WS_C),
        .STROBE_C (WP_C),
        .HOLD_C   (WH_C),
        .ACCESS_C (ACC_C),
        .TURN_C   (TA_C)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .pu_done_i   (pu_done),
        .req_valid_i (req_valid),
        .req_write_i (req_write),
        .req_addr_i  (req_addr),
        .req_wdata_i (req_wdata),
        .req_ready_o (req_ready),
        .rsp_valid_o (rsp_valid),
        .rsp_data_o  (rsp_data),
        .mem_addr_o  (mem_addr),
        .mem_cs_n_o  (mem_cs_n),
        .mem_we_n_o  (mem_we_n),
        .mem_oe_n_o  (mem_oe_n),
        .mem_dq_o    (mem_dq_out),
        .mem_dq_oe_o (mem_dq_oe),
        .mem_dq_i    (mem_dq_in)
    );

endmodule

// File: tb/sim_sram_ctl.sv
`timescale 1ns/1ps
module sim_sram_ctl;
    localparam int PU_EXP  = 30000; // 150 us at 5 ns
    localparam int WP_EXP  = 2;     // ceil(8/5), ceil(6/5)
    localparam int ACC_EXP = 2;     // ceil(10/5)
    localparam int WR_LAT  = 5;
    localparam int RD_LAT  = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [18:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic req_ready, rsp_valid, mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe;
    logic [7:0]  rsp_data, mem_dq_out, mem_dq_in;
    logic [18:0] mem_addr;

    always #2.5 clk = ~clk;

    sram_ctl u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .mem_addr(mem_addr),
        .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
        .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
    );

    int checks = 0;
    int errors = 0;
    int edges  = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] dflt(input logic [18:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h5A;
    endfunction

    always @(posedge clk) if (rst_n) edges <= edges + 1;

    // ---------------- memory model ----------------
    logic [7:0] model_mem [int];
    int         rd_stable = 0;
    logic [7:0] rd_byte = 8'h00;
    logic [18:0] last_addr = '0;
    bit         wr_pend = 0;
    logic [18:0] wr_addr;
    logic [7:0] wr_data;

    assign mem_dq_in = (rd_stable >= ACC_EXP) ? rd_byte : 8'hEE;

    always @(negedge clk) begin
        if (!mem_cs_n && !mem_oe_n && mem_we_n) begin
            rd_stable = (rd_stable > 0 && mem_addr == last_addr) ? rd_stable + 1 : 1;
            rd_byte   = model_mem.exists(int'(mem_addr)) ? model_mem[int'(mem_addr)] : dflt(mem_addr);
        end else begin
            rd_stable = 0;
        end
        last_addr = mem_addr;
        if (!mem_cs_n && !mem_we_n) begin
            wr_pend = 1;
            wr_addr = mem_addr;
            wr_data = mem_dq_oe ? mem_dq_out : 8'hEE;
        end else if (wr_pend && mem_we_n) begin
            model_mem[int'(wr_addr)] = wr_data;
            wr_pend = 0;
        end
    end

    // ---------------- scoreboard ----------------
    logic [7:0] ref_mem [int];
    logic [7:0] exp_q [$];
    logic [7:0] last_rsp = 8'h00;

    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R5 unexpected response", int'(rsp_data), -1);
            end else begin
                logic [7:0] e;
                e = exp_q.pop_front();
                chk(rsp_data == e, "R5/R10 read data", int'(rsp_data), int'(e));
                last_rsp = e;
            end
        end
    end

    // ---------------- pin protocol monitor ----------------
    bit prev_we = 1, prev_oe = 1, prev_cs = 1, prev_dq_oe = 0, prev_rv = 0;
    int we_run = 0, dq_run = 0, oe_run = 0;
    logic [7:0] dq_first;
    logic [18:0] a_first;
    bit fight = 0, idle_bad = 0, rv_double = 0, lock_cs_bad = 0, wr_oe_bad = 0, dq_moved = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (!mem_we_n) begin
                if (prev_we) chk(!prev_cs, "R3 cs low before we falls", int'(prev_cs), 0);
                we_run++;
                if (!mem_oe_n) wr_oe_bad = 1;
            end else if (!prev_we) begin
                chk(we_run == WP_EXP, "R3 we low cycles", we_run, WP_EXP);
                we_run = 0;
            end
            if (mem_dq_oe) begin
                if (!prev_dq_oe) begin dq_first = mem_dq_out; a_first = mem_addr; end
                else if (mem_dq_out != dq_first || mem_addr != a_first) dq_moved = 1;
                dq_run++;
            end else if (prev_dq_oe) begin
                chk(dq_run == WP_EXP + 1, "R4 drive cycles", dq_run, WP_EXP + 1);
                dq_run = 0;
            end
            if (!mem_oe_n) begin
                if (prev_oe) chk(!prev_dq_oe, "R7 driver off before read", int'(prev_dq_oe), 0);
                oe_run++;
            end else if (!prev_oe) begin
                chk(oe_run == ACC_EXP, "R5 access cycles", oe_run, ACC_EXP);
                oe_run = 0;
            end
            if (mem_dq_oe && !mem_oe_n) fight = 1;
            if (req_ready && (!mem_cs_n || !mem_we_n || !mem_oe_n || mem_dq_oe)) idle_bad = 1;
            if (rsp_valid && prev_rv) rv_double = 1;
            if (edges < PU_EXP && (!mem_cs_n || rsp_valid)) lock_cs_bad = 1;
        end
        prev_we = mem_we_n; prev_oe = mem_oe_n; prev_cs = mem_cs_n;
        prev_dq_oe = mem_dq_oe; prev_rv = rsp_valid;
    end

    // ---------------- driver ----------------
    task automatic do_req(input bit wr, input logic [18:0] a, input logic [7:0] dat, output int lat);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = dat;
        if (wr) ref_mem[int'(a)] = dat;
        else exp_q.push_back(ref_mem.exists(int'(a)) ? ref_mem[int'(a)] : dflt(a));
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        lat = 0;
        while (!req_ready) begin @(negedge clk); lat++; end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "watchdog expired", 0, 1);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int lat;
        repeat (4) @(negedge clk);
        chk(mem_cs_n && mem_we_n && mem_oe_n, "R9 reset pins idle", int'(mem_cs_n), 1);
        chk(!mem_dq_oe && !rsp_valid, "R9 reset no drive/response", int'(mem_dq_oe), 0);
        chk(!req_ready, "R1 not ready in reset", int'(req_ready), 0);
        rst_n = 1'b1;
        // R2: requests offered during the power-up wait
        while (edges < 10) @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = 19'h00123; req_wdata = 8'hC3;
        while (edges < 200) @(negedge clk);
        req_write = 1'b0;
        while (edges < 300) @(negedge clk);
        req_valid = 1'b0;
        while (edges < PU_EXP) @(negedge clk);
        chk(!req_ready, "R1 ready still low at PU", int'(req_ready), 0);
        @(negedge clk);
        chk(req_ready, "R1 ready high at PU+1", int'(req_ready), 1);
        chk(!lock_cs_bad, "R2 no selection or response in lockout", int'(lock_cs_bad), 0);
        // R2: write offered in lockout must not have landed
        do_req(0, 19'h00123, 8'h00, lat);
        chk(lat == RD_LAT, "R8 read ready latency", lat, RD_LAT);
        do_req(1, 19'h00040, 8'hA5, lat);
        chk(lat == WR_LAT, "R8 write ready latency", lat, WR_LAT);
        // R10 back-to-back read after write
        do_req(0, 19'h00040, 8'h00, lat);
        do_req(1, 19'h7FFFF, 8'h3C, lat);
        do_req(1, 19'h00000, 8'h81, lat);
        do_req(0, 19'h7FFFF, 8'h00, lat);
        do_req(0, 19'h00000, 8'h00, lat);
        for (int i = 0; i < 6; i++) do_req(0, 19'(i * 4099 + 7), 8'h00, lat);
        do_req(1, 19'h00040, 8'h5F, lat);
        do_req(0, 19'h00040, 8'h00, lat);
        // R6: response byte holds across a write
        repeat (2) @(negedge clk);
        do_req(1, 19'h01234, 8'h99, lat);
        repeat (3) @(negedge clk);
        chk(rsp_data == 8'h5F, "R6 rsp_data held across write", int'(rsp_data), 8'h5F);
        do_req(0, 19'h01234, 8'h00, lat);
        repeat (6) @(negedge clk);
        chk(exp_q.size() == 0, "R5 all reads answered", exp_q.size(), 0);
        chk(last_rsp == 8'h99, "R10 last read value", int'(last_rsp), 8'h99);
        chk(!fight, "R7 no drive while output enabled", int'(fight), 0);
        chk(!idle_bad, "R9 pins idle while ready", int'(idle_bad), 0);
        chk(!rv_double, "R5 valid one cycle", int'(rv_double), 0);
        chk(!wr_oe_bad, "R3 oe high during write", int'(wr_oe_bad), 0);
        chk(!dq_moved, "R4 address/data stable while driven", int'(dq_moved), 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule